// File: doc/BRIEF.md
# Segment Address Translation Unit

The unit turns a segment-relative offset into a 32-bit linear address and checks the access against the attributes cached for the chosen segment. It holds six segment slots. Each slot keeps a 16-bit selector together with a cached descriptor: base, limit, type/permission bits and a descriptor privilege level. Two table-base registers record where the global and the local descriptor tables live.

An access request carries an offset, an access kind, an optional slot override and the current privilege level. The unit picks a slot: from the kind when no override is given, from the override otherwise. It applies the null, privilege, limit and permission checks. One clock later it returns either a linear address with a valid strobe or a fault code. A slot is filled through a load port: the selector and the descriptor fields arrive together. While a selector is presented on that port, the unit shows the memory address of its descriptor so that an outside agent can fetch it. Reading descriptor memory and paging are handled elsewhere.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset every slot holds selector 0 with base 0, limit 0, no permission bits and privilege 0. Both table bases are 0. `lin_valid`, `fault_code` and `lin_addr` are 0.
- R2: Without an override the slot comes from `req_kind`. Kind 0 (control-transfer fetch) uses slot 0 (code). Kind 1 (push/pop) uses slot 2 (stack). Kinds 2 (load) and 3 (store) use slot 1 (data).
- R3: With `req_ovr_en` high, `req_ovr_slot` names the slot. Slots 3, 4 and 5 (extra segments) are reachable only this way. An override value of 6 or 7 yields the null fault.
- R4: A request in cycle N gives its result after the next rising edge. If there is no fault, `lin_valid` is 1, `fault_code` is 0 and `lin_addr` = base + offset modulo 2^32. If the request faults, `lin_valid` and `lin_addr` are 0. With no request all three outputs are 0.
- R5: A slot with base 0 and limit 0xFFFFFFFF whose permissions allow the access translates every 32-bit offset to itself, with no fault.
- R6: Fault codes are 1 null, 2 privilege, 3 limit and 4 protection. When several checks fail, the lowest code is reported. An offset greater than the slot limit gives code 3.
- R7: Permission bits are attr[2] execute (code segment), attr[1] readable code and attr[0] writable. These give code 4: a fetch from a slot without execute; a load from a code slot without readable; a store to a code slot or to a slot without writable; a push/pop to a slot without writable.
- R8: The effective level is the larger of `req_cpl` and the selector's bits [1:0]. If it exceeds the slot's descriptor privilege level, the access gives code 2.
- R9: A selector with index bits [15:3] equal to 0 and table bit [2] equal to 0 is null. Any access through it gives code 1.
- R10: A load on the load port writes the slot at the rising edge. A request in the same cycle still sees the old slot contents; later requests see the new ones.
- R11: `desc_addr` is combinational from `ld_sel`. It equals the local table base when bit [2] is 1 (global otherwise) plus index × 8, modulo 2^32.
- R12: A table-base write (`tbl_wr_local` picks local when 1) takes effect only when `req_cpl` is 0. At any other level the write leaves both bases unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_offset | input | 32 | Segment-relative offset |
| req_kind | input | 2 | 0 fetch, 1 push/pop, 2 load, 3 store |
| req_ovr_en | input | 1 | Use explicit slot instead of the implied one |
| req_ovr_slot | input | 3 | Explicit slot number |
| req_cpl | input | 2 | Current privilege level (also gates table writes) |
| ld_valid | input | 1 | Write a slot this cycle |
| ld_slot | input | 3 | Slot to write |
| ld_sel | input | 16 | Selector being loaded |
| ld_base | input | 32 | Descriptor base |
| ld_limit | input | 32 | Descriptor limit (highest legal offset) |
| ld_attr | input | 3 | {execute, readable code, writable} |
| ld_dpl | input | 2 | Descriptor privilege level |
| tbl_wr_en | input | 1 | Write a table-base register |
| tbl_wr_local | input | 1 | 1 selects the local table base |
| tbl_wr_base | input | 32 | New table base |
| desc_addr | output | 32 | Memory address of the descriptor for `ld_sel` |
| lin_valid | output | 1 | Translation succeeded |
| lin_addr | output | 32 | Linear address |
| fault_code | output | 3 | 0 none, 1 null, 2 privilege, 3 limit, 4 protection |

## Verification
The bench drives offsets at the edges of the limit: exactly the limit, one past it, 0 and 0xFFFFFFFF on a flat slot. A comparison written as greater-or-equal, or a carry that leaks past bit 31, would fault or misplace those addresses. It stacks failing checks on one access, such as a privileged-level violation on a non-readable code slot, or a null selector at level 3, so that a wrong priority order shows up as the wrong code. It overlaps a slot load with an access to that slot, which catches a design that forwards the new descriptor too early. It tries table writes at level 3, whose effect would surface on `desc_addr`. It also sends override values 6 and 7, which a design without a range check would turn into a read of a missing slot.

// File: rtl/seg_pkg.sv
package seg_pkg;
   typedef enum logic [1:0] {
      K_FETCH = 2'd0,
      K_STACK = 2'd1,
      K_LOAD  = 2'd2,
      K_STORE = 2'd3
   } acc_kind_e;

   typedef enum logic [2:0] {
      F_NONE  = 3'd0,
      F_NULL  = 3'd1,
      F_PRIV  = 3'd2,
      F_LIMIT = 3'd3,
      F_PROT  = 3'd4
   } fault_e;

   typedef struct packed {
      logic exec;
      logic rd;
      logic wr;
   } seg_attr_t;

   localparam int SLOT_CODE  = 0;
   localparam int SLOT_DATA  = 1;
   localparam int SLOT_STACK = 2;
endpackage

// File: rtl/seg_slot_bank.sv
module seg_slot_bank #(
   parameter int NSEG   = 6,
   parameter int AW     = 32,
   parameter int SELW   = 16,
   parameter int SLOT_W = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ld_valid,
   input  logic [SLOT_W-1:0]          ld_slot,
   input  logic [SELW-1:0]            ld_sel,
   input  logic [AW-1:0]              ld_base,
   input  logic [AW-1:0]              ld_limit,
   input  seg_pkg::seg_attr_t         ld_attr,
   input  logic [1:0]                 ld_dpl,
   output logic [NSEG-1:0][SELW-1:0]  sel_q,
   output logic [NSEG-1:0][AW-1:0]    base_q,
   output logic [NSEG-1:0][AW-1:0]    limit_q,
   output seg_pkg::seg_attr_t [NSEG-1:0] attr_q,
   output logic [NSEG-1:0][1:0]       dpl_q
);
   for (genvar g = 0; g < NSEG; g++) begin : g_slot
      logic hit;
      assign hit = ld_valid && (ld_slot == SLOT_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_q[g]   <= '0;
            base_q[g]  <= '0;
            limit_q[g] <= '0;
            attr_q[g]  <= '0;
            dpl_q[g]   <= '0;
         end else if (hit) begin
            sel_q[g]   <= ld_sel;
            base_q[g]  <= ld_base;
            limit_q[g] <= ld_limit;
            attr_q[g]  <= ld_attr;
            dpl_q[g]   <= ld_dpl;
         end
      end
   end
endmodule

// File: rtl/seg_pick.sv
module seg_pick #(
   parameter int NSEG   = 6,
   parameter int SLOT_W = 3
) (
   input  logic [1:0]        kind,
   input  logic              ovr_en,
   input  logic [SLOT_W-1:0] ovr_slot,
   output logic [SLOT_W-1:0] slot,
   output logic              slot_ok
);
   import seg_pkg::*;

   always_comb begin
      if (ovr_en) begin
         slot = ovr_slot;
      end else begin
         unique case (kind)
            K_FETCH: slot = SLOT_W'(SLOT_CODE);
            K_STACK: slot = SLOT_W'(SLOT_STACK);
            default: slot = SLOT_W'(SLOT_DATA);
         endcase
      end
      slot_ok = (int'(slot) < NSEG);
   end
endmodule

// File: rtl/seg_check.sv
module seg_check #(
   parameter int AW         = 32,
   parameter int SELW       = 16,
   parameter bit PRIV_CHECK = 1'b1
) (
   input  logic               slot_ok,
   input  logic [SELW-1:0]    sel,
   input  logic [AW-1:0]      base,
   input  logic [AW-1:0]      limit,
   input  seg_pkg::seg_attr_t attr,
   input  logic [1:0]         dpl,
   input  logic [AW-1:0]      offset,
   input  logic [1:0]         kind,
   input  logic [1:0]         cpl,
   output logic [2:0]         fault,
   output logic [AW-1:0]      lin
);
   import seg_pkg::*;

   logic is_null, over_lim, bad_perm, bad_priv;
   logic [1:0] eff_lvl;

   assign is_null  = !slot_ok || ((sel[SELW-1:3] == '0) && !sel[2]);
   assign over_lim = offset > limit;
   assign eff_lvl  = (cpl > sel[1:0]) ? cpl : sel[1:0];

   if (PRIV_CHECK) begin : g_priv
      assign bad_priv = eff_lvl > dpl;
   end else begin : g_nopriv
      assign bad_priv = 1'b0;
   end

   always_comb begin
      unique case (kind)
         K_FETCH: bad_perm = !attr.exec;
         K_LOAD:  bad_perm = attr.exec && !attr.rd;
         K_STORE: bad_perm = attr.exec || !attr.wr;
         default: bad_perm = !attr.wr;
      endcase
   end

   always_comb begin
      if (is_null)       fault = F_NULL;
      else if (bad_priv) fault = F_PRIV;
      else if (over_lim) fault = F_LIMIT;
      else if (bad_perm) fault = F_PROT;
      else               fault = F_NONE;
   end

   assign lin = base + offset;
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit #(
   parameter int NSEG       = 6,
   parameter int AW         = 32,
   parameter int SELW       = 16,
   parameter int SLOT_W     = 3,
   parameter bit PRIV_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [AW-1:0]     req_offset,
   input  logic [1:0]        req_kind,
   input  logic              req_ovr_en,
   input  logic [SLOT_W-1:0] req_ovr_slot,
   input  logic [1:0]        req_cpl,
   input  logic              ld_valid,
   input  logic [SLOT_W-1:0] ld_slot,
   input  logic [SELW-1:0]   ld_sel,
   input  logic [AW-1:0]     ld_base,
   input  logic [AW-1:0]     ld_limit,
   input  logic [2:0]        ld_attr,
   input  logic [1:0]        ld_dpl,
   input  logic              tbl_wr_en,
   input  logic              tbl_wr_local,
   input  logic [AW-1:0]     tbl_wr_base,
   output logic [AW-1:0]     desc_addr,
   output logic              lin_valid,
   output logic [AW-1:0]     lin_addr,
   output logic [2:0]        fault_code
);
   import seg_pkg::*;

   localparam int IDXW = SELW - 3;

   if (NSEG < 3 || (1 << SLOT_W) < NSEG) begin : g_bad_slots
      $error("seg_xlate_unit: NSEG must be at least 3 and fit in SLOT_W bits");
   end
   if (SELW < 4 || SELW > AW) begin : g_bad_selw
      $error("seg_xlate_unit: SELW must lie between 4 and AW");
   end

   logic [NSEG-1:0][SELW-1:0] sel_q;
   logic [NSEG-1:0][AW-1:0]   base_q, limit_q;
   seg_attr_t [NSEG-1:0]      attr_q;
   logic [NSEG-1:0][1:0]      dpl_q;

   seg_slot_bank #(.NSEG(NSEG), .AW(AW), .SELW(SELW), .SLOT_W(SLOT_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_slot(ld_slot),
      .ld_sel(ld_sel), .ld_base(ld_base), .ld_limit(ld_limit),
      .ld_attr(seg_attr_t'(ld_attr)), .ld_dpl(ld_dpl),
      .sel_q(sel_q), .base_q(base_q), .limit_q(limit_q),
      .attr_q(attr_q), .dpl_q(dpl_q)
   );

   logic [SLOT_W-1:0] slot;
   logic              slot_ok;

   seg_pick #(.NSEG(NSEG), .SLOT_W(SLOT_W)) u_pick (
      .kind(req_kind), .ovr_en(req_ovr_en), .ovr_slot(req_ovr_slot),
      .slot(slot), .slot_ok(slot_ok)
   );

   logic [SELW-1:0] c_sel;
   logic [AW-1:0]   c_base, c_limit;
   seg_attr_t       c_attr;
   logic [1:0]      c_dpl;

   always_comb begin
      c_sel   = '0;
      c_base  = '0;
      c_limit = '0;
      c_attr  = '0;
      c_dpl   = '0;
      for (int i = 0; i < NSEG; i++) begin
         if (slot == SLOT_W'(i)) begin
            c_sel   = sel_q[i];
            c_base  = base_q[i];
            c_limit = limit_q[i];
            c_attr  = attr_q[i];
            c_dpl   = dpl_q[i];
         end
      end
   end

   logic [2:0]    c_fault;
   logic [AW-1:0] c_lin;

   seg_check #(.AW(AW), .SELW(SELW), .PRIV_CHECK(PRIV_CHECK)) u_check (
      .slot_ok(slot_ok), .sel(c_sel), .base(c_base), .limit(c_limit),
      .attr(c_attr), .dpl(c_dpl), .offset(req_offset), .kind(req_kind),
      .cpl(req_cpl), .fault(c_fault), .lin(c_lin)
   );

   logic [AW-1:0] gdt_q, ldt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gdt_q <= '0;
         ldt_q <= '0;
      end else if (tbl_wr_en && req_cpl == 2'd0) begin
         if (tbl_wr_local) ldt_q <= tbl_wr_base;
         else              gdt_q <= tbl_wr_base;
      end
   end

   logic [IDXW-1:0] ld_index;
   assign ld_index  = ld_sel[SELW-1:3];
   assign desc_addr = (ld_sel[2] ? ldt_q : gdt_q) + AW'({ld_index, 3'b000});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lin_valid  <= 1'b0;
         lin_addr   <= '0;
         fault_code <= F_NONE;
      end else if (req_valid) begin
         lin_valid  <= (c_fault == F_NONE);
         lin_addr   <= (c_fault == F_NONE) ? c_lin : '0;
         fault_code <= c_fault;
      end else begin
         lin_valid  <= 1'b0;
         lin_addr   <= '0;
         fault_code <= F_NONE;
      end
   end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [1:0]    req_cpl,
   input logic          tbl_wr_en,
   input logic          lin_valid,
   input logic [AW-1:0] lin_addr,
   input logic [2:0]    fault_code,
   input logic [AW-1:0] gdt_q,
   input logic [AW-1:0] ldt_q
);
   // R4
   valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lin_valid |-> fault_code == 3'd0);

   // R4
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!lin_valid && fault_code == 3'd0 && lin_addr == '0));

   // R4
   answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (lin_valid || fault_code != 3'd0));

   // R6
   code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_code <= 3'd4);

   // R12
   tbl_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_wr_en && req_cpl != 2'd0) |=> ($stable(gdt_q) && $stable(ldt_q)));
endmodule

bind seg_xlate_unit seg_xlate_chk #(.AW(AW)) u_xlate_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cpl(req_cpl),
   .tbl_wr_en(tbl_wr_en), .lin_valid(lin_valid), .lin_addr(lin_addr),
   .fault_code(fault_code), .gdt_q(gdt_q), .ldt_q(ldt_q)
);

// File: tb/seg_xlate_unit_test.sv
`timescale 1ns/1ps
module seg_xlate_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 0;
   logic [31:0] req_offset = 0;
   logic [1:0]  req_kind = 0;
   logic        req_ovr_en = 0;
   logic [2:0]  req_ovr_slot = 0;
   logic [1:0]  req_cpl = 0;
   logic        ld_valid = 0;
   logic [2:0]  ld_slot = 0;
   logic [15:0] ld_sel = 0;
   logic [31:0] ld_base = 0, ld_limit = 0;
   logic [2:0]  ld_attr = 0;
   logic [1:0]  ld_dpl = 0;
   logic        tbl_wr_en = 0, tbl_wr_local = 0;
   logic [31:0] tbl_wr_base = 0;
   logic [31:0] desc_addr, lin_addr;
   logic        lin_valid;
   logic [2:0]  fault_code;

   always #2.5 clk = ~clk;

   seg_xlate_unit uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
      .req_kind(req_kind), .req_ovr_en(req_ovr_en), .req_ovr_slot(req_ovr_slot),
      .req_cpl(req_cpl), .ld_valid(ld_valid), .ld_slot(ld_slot), .ld_sel(ld_sel),
      .ld_base(ld_base), .ld_limit(ld_limit), .ld_attr(ld_attr), .ld_dpl(ld_dpl),
      .tbl_wr_en(tbl_wr_en), .tbl_wr_local(tbl_wr_local), .tbl_wr_base(tbl_wr_base),
      .desc_addr(desc_addr), .lin_valid(lin_valid), .lin_addr(lin_addr),
      .fault_code(fault_code)
   );

   int    checks = 0;
   int    errors = 0;
   bit    finished = 0;
   string cur_tag = "R4";

   // behavioural reference state
   logic [15:0] m_sel  [6];
   logic [31:0] m_base [6];
   logic [31:0] m_lim  [6];
   logic [2:0]  m_attr [6];
   logic [1:0]  m_dpl  [6];
   logic [31:0] m_gdt, m_ldt;
   logic        e_v;
   logic [31:0] e_a;
   logic [2:0]  e_f;
   string       e_tag = "R4";

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [2:0] model_fault(input int s, input logic [31:0] off,
                                              input logic [1:0] k, input logic [1:0] c);
      int lvl;
      bit x, r, w, perm_bad;
      if (s > 5) return 3'd1;
      if (m_sel[s][15:3] == 0 && m_sel[s][2] == 0) return 3'd1;
      lvl = (int'(c) > int'(m_sel[s][1:0])) ? int'(c) : int'(m_sel[s][1:0]);
      if (lvl > int'(m_dpl[s])) return 3'd2;
      if (off > m_lim[s]) return 3'd3;
      x = m_attr[s][2]; r = m_attr[s][1]; w = m_attr[s][0];
      case (k)
         2'd0: perm_bad = !x;
         2'd1: perm_bad = !w;
         2'd2: perm_bad = x && !r;
         default: perm_bad = x || !w;
      endcase
      return perm_bad ? 3'd4 : 3'd0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 6; i++) begin
            m_sel[i] = 0; m_base[i] = 0; m_lim[i] = 0; m_attr[i] = 0; m_dpl[i] = 0;
         end
         m_gdt = 0; m_ldt = 0;
         e_v = 0; e_a = 0; e_f = 0;
      end else begin
         if (req_valid) begin
            int s;
            if (req_ovr_en) s = int'(req_ovr_slot);
            else if (req_kind == 2'd0) s = 0;
            else if (req_kind == 2'd1) s = 2;
            else s = 1;
            e_f = model_fault(s, req_offset, req_kind, req_cpl);
            e_v = (e_f == 0);
            e_a = e_v ? m_base[s] + req_offset : 32'd0;
         end else begin
            e_v = 0; e_a = 0; e_f = 0;
         end
         e_tag = cur_tag;
         if (ld_valid && ld_slot < 6) begin
            m_sel[ld_slot] = ld_sel; m_base[ld_slot] = ld_base; m_lim[ld_slot] = ld_limit;
            m_attr[ld_slot] = ld_attr; m_dpl[ld_slot] = ld_dpl;
         end
         if (tbl_wr_en && req_cpl == 0) begin
            if (tbl_wr_local) m_ldt = tbl_wr_base;
            else m_gdt = tbl_wr_base;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [31:0] e_d;
         check(lin_valid == e_v && fault_code == e_f && lin_addr == e_a, e_tag,
               {28'd0, lin_valid, fault_code, lin_addr}, {28'd0, e_v, e_f, e_a});
         e_d = (ld_sel[2] ? m_ldt : m_gdt) + {16'd0, ld_sel[15:3], 3'b000};
         check(desc_addr == e_d, "R11 descriptor address", {32'd0, desc_addr}, {32'd0, e_d});
      end
   end

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic acc(input logic [31:0] off, input logic [1:0] k, input bit oe,
                      input logic [2:0] os, input logic [1:0] c, input string t);
      req_valid = 1; req_offset = off; req_kind = k; req_ovr_en = oe;
      req_ovr_slot = os; req_cpl = c; cur_tag = t;
      tick;
      req_valid = 0; req_ovr_en = 0;
   endtask

   task automatic ld(input logic [2:0] s, input logic [15:0] sel, input logic [31:0] b,
                     input logic [31:0] lim, input logic [2:0] a, input logic [1:0] d);
      ld_valid = 1; ld_slot = s; ld_sel = sel; ld_base = b; ld_limit = lim;
      ld_attr = a; ld_dpl = d; cur_tag = "R10";
      tick;
      ld_valid = 0;
   endtask

   task automatic twr(input bit loc, input logic [31:0] b, input logic [1:0] c);
      tbl_wr_en = 1; tbl_wr_local = loc; tbl_wr_base = b; req_cpl = c; cur_tag = "R12";
      tick;
      tbl_wr_en = 0; req_cpl = 0;
   endtask

   initial begin
      #1000000;
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      tick; tick; tick;
      // R1: outputs during reset
      check(lin_valid == 0 && fault_code == 0 && lin_addr == 0, "R1 outputs in reset",
            {28'd0, lin_valid, fault_code, lin_addr}, 64'd0);
      check(desc_addr == 0, "R1 table bases in reset", {32'd0, desc_addr}, 64'd0);
      rst_n = 1;
      tick;
      // R1 / R9: reset slots are null
      acc(32'h10, 2'd2, 0, 0, 0, "R1 null after reset");
      acc(32'h10, 2'd0, 0, 0, 0, "R1 null code after reset");
      // R12: table writes
      twr(0, 32'h0000_1000, 0);
      twr(1, 32'h0000_8000, 0);
      ld_sel = 16'h002B; tick;
      twr(0, 32'hDEAD_0000, 3);
      twr(1, 32'hBEEF_0000, 1);
      ld_sel = 16'h000C; tick;
      ld_sel = 16'hFFFF; tick;
      // descriptor loads
      ld(0, 16'h0008, 32'h1000_0000, 32'hFFFF_FFFF, 3'b110, 0);
      ld(1, 16'h0010, 32'h0000_0000, 32'hFFFF_FFFF, 3'b001, 3);
      ld(2, 16'h0018, 32'h2000_0000, 32'h0000_FFFF, 3'b001, 3);
      ld(3, 16'h0023, 32'h0000_0300, 32'h0000_00FF, 3'b000, 3);
      ld(4, 16'h002B, 32'h0004_0000, 32'hFFFF_FFFF, 3'b100, 0);
      // R4: shifted code base
      acc(32'hF010_0DB8, 2'd0, 0, 0, 0, "R4 code base shift");
      acc(32'h0000_0000, 2'd0, 0, 0, 0, "R4 code offset 0");
      // R5: flat data
      acc(32'h0000_0000, 2'd2, 0, 0, 3, "R5 flat zero");
      acc(32'hFFFF_FFFF, 2'd3, 0, 0, 3, "R5 flat top");
      acc(32'h1234_5678, 2'd2, 0, 0, 0, "R5 flat mid");
      // R2: implicit choice
      acc(32'h0000_0040, 2'd1, 0, 0, 3, "R2 stack implied");
      acc(32'h0000_0040, 2'd3, 0, 0, 3, "R2 store implied data");
      // R3: override
      acc(32'h0000_0010, 2'd2, 1, 3, 3, "R3 extra slot by override");
      acc(32'h0000_0010, 2'd2, 1, 5, 0, "R3 unloaded extra slot null");
      acc(32'h0000_0010, 2'd2, 1, 6, 0, "R3 override 6");
      acc(32'h0000_0010, 2'd2, 1, 7, 0, "R3 override 7");
      // R6: limit edges and priority
      acc(32'h0000_FFFF, 2'd1, 0, 0, 3, "R6 at limit");
      acc(32'h0001_0000, 2'd1, 0, 0, 3, "R6 past limit");
      acc(32'h0000_0100, 2'd3, 1, 3, 3, "R6 limit before protection");
      // R7: permissions
      acc(32'h0000_0010, 2'd3, 1, 3, 3, "R7 store read-only");
      acc(32'h0000_0010, 2'd0, 1, 1, 0, "R7 fetch no execute");
      acc(32'h0000_0010, 2'd3, 1, 0, 0, "R7 store to code");
      acc(32'h0000_0010, 2'd2, 1, 0, 0, "R7 load readable code");
      acc(32'h0000_0010, 2'd1, 1, 0, 0, "R7 push to code");
      // R8: privilege
      acc(32'h0000_0010, 2'd0, 0, 0, 3, "R8 fetch at level 3");
      acc(32'h0000_0010, 2'd2, 1, 4, 0, "R8 selector level over descriptor");
      acc(32'h0000_0010, 2'd0, 1, 4, 0, "R8 selector level on fetch");
      // R9: null priority over privilege
      acc(32'h0000_0010, 2'd2, 1, 5, 3, "R9 null before privilege");
      // R10: same-cycle load and access
      ld_valid = 1; ld_slot = 1; ld_sel = 16'h0010; ld_base = 32'h0000_5000;
      ld_limit = 32'hFFFF_FFFF; ld_attr = 3'b001; ld_dpl = 3;
      acc(32'h0000_0020, 2'd2, 0, 0, 3, "R10 access with load");
      ld_valid = 0;
      acc(32'h0000_0020, 2'd2, 0, 0, 3, "R10 access after load");
      ld(5, 16'h0004, 32'h0000_0000, 32'hFFFF_FFFF, 3'b001, 3);
      acc(32'h0000_0020, 2'd3, 1, 5, 3, "R9 local index 0 not null");
      // random mix
      for (int n = 0; n < 400; n++) begin
         if ($urandom_range(0, 3) == 0) begin
            ld_valid = 1; ld_slot = 3'($urandom_range(0, 5));
            ld_sel = 16'($urandom_range(0, 65535)); ld_base = $urandom;
            ld_limit = ($urandom_range(0, 1) == 1) ? 32'hFFFF_FFFF : $urandom;
            ld_attr = 3'($urandom_range(0, 7)); ld_dpl = 2'($urandom_range(0, 3));
         end
         acc($urandom, 2'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
             3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), "R4 random mix");
         ld_valid = 0;
      end
      tick; tick;
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule